// File: doc/BRIEF.md
# Operator Console Control Sequencer

This block is the front-panel control logic of a small 16-bit processor. The operator builds a 16-bit word in a switch register by pressing data buttons, then issues one-shot commands. These commands load the location counter or a selected CPU register from that word, write it to memory, rewrite the status flags, halt or resume the processor, or apply a master clear. The block turns each accepted command into single-cycle write strobes for the CPU register file, the location counter, the memory write port and the status register it holds. It also produces a pulse that tells the display latches when to refresh.

Every pushbutton input is asynchronous. Each one passes through a two-stage synchronizer and a rising-edge detector, so one press yields one strobe. A two-bit key input sets how much of the panel is live. Commands that alter machine state are accepted only with the key at ON while the processor is halted. When several commands arrive together, a fixed priority picks one of them. The halt flag is kept apart from operator edits of the status word.

Top module: `console_seq`

## Requirements
- R1: A rising edge on bit i of `data_btn` sets `sw_reg[i]` to 1 and leaves the other bits unchanged. The new value is visible three clock edges after the input changes. This applies only with `key_mode` at ON (1) or PROG (2).
- R2: A switch-clear command sets `sw_reg` to zero. It produces no register, location-counter or memory write. A data press in the same cycle still sets its bit.
- R3: Set-location, set-register, set-status, store and increment-store are carried out only when `key_mode` is ON (1) and the halt flag is 1. Otherwise they produce no strobe and no status change. An accepted set-location pulses `l_we` with `l_wdata` = `sw_reg`, three edges after the button changes.
- R4: Set-register pulses `reg_we` with `reg_wdata` = `sw_reg` and `reg_wsel` = `reg_sel`. The select codes are 0 M, 1 X, 2 A, 3 B and 4 E. A select code of 5 or above produces no write.
- R5: The status word has these bits: bit0 carry, bit1 overflow, bit2 parity error, bit3 halt, bit4 interrupts disabled. Set-status loads bits 0, 1, 2 and 4 from the same bits of `sw_reg` and leaves bit3 unchanged.
- R6: Store pulses `mem_we` with `mem_addr` = `l_value` and `mem_wdata` = `sw_reg`. In the same cycle it writes the same data into M (`reg_we`, `reg_wsel` = 0). It does not touch the location counter.
- R7: Increment-store pulses `l_we` with `l_value`+1, which wraps from FFFF to 0000. It then stores `sw_reg` at that incremented address, also through M.
- R8: The run button clears the halt flag. The halt button sets it. Both act with `key_mode` at ON or PROG.
- R9: `disp_refresh` pulses one edge after a `line_tick` while the halt flag is 0 and `refresh_inhibit` is 0. It also pulses on every halt event and on every accepted set, store or increment-store command. It does not pulse on a `line_tick` while the processor is halted or while refresh is inhibited.
- R10: A `halt_instr` pulse sets the halt flag one edge later. A `wake_irq` pulse clears it one edge later. If both arrive in the same cycle, halt wins.
- R11: With `key_mode` at LOCK (3) or OFF (0), every button is ignored, and `sw_reg`, the strobes and the halt flag are left unchanged. `lamp_test_o` follows `lamp_test` two edges later in every mode except OFF, where it is 0.
- R12: With `key_mode` at PROG (2), data buttons, switch-clear, halt and run work, while all set, store and master-clear commands are ignored.
- R13: Master clear, allowed with the key at ON, loads the status word with 5'b11000 (halt and interrupts-disabled set, the rest clear). It pulses `irq_disarm` and leaves `sw_reg` unchanged. Reset gives the same status value and clears `sw_reg`.
- R14: `cmd_btn` bit positions are: 0 master clear, 1 halt, 2 run, 3 set-status, 4 set-location, 5 set-register, 6 store, 7 increment-store, 8 switch-clear. When several permitted commands rise in the same cycle, only the one with the lowest bit index is executed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| key_mode | input | 2 | Key switch: 0 OFF, 1 ON, 2 PROG, 3 LOCK |
| data_btn | input | 16 | Asynchronous data pushbuttons |
| cmd_btn | input | 9 | Asynchronous command pushbuttons (bit map in R14) |
| lamp_test | input | 1 | Asynchronous lamp-test button level |
| reg_sel | input | 3 | Register select knob |
| l_value | input | 16 | Current location counter from the CPU |
| line_tick | input | 1 | Synchronous line-frequency pulse |
| refresh_inhibit | input | 1 | Suppresses periodic display refresh |
| halt_instr | input | 1 | Synchronous pulse: a halt instruction executed |
| wake_irq | input | 1 | Synchronous pulse: an interrupt that resumes a halted CPU |
| sw_reg | output | 16 | Switch register contents |
| reg_we | output | 1 | CPU register write strobe |
| reg_wsel | output | 3 | CPU register being written |
| reg_wdata | output | 16 | CPU register write data |
| l_we | output | 1 | Location counter write strobe |
| l_wdata | output | 16 | Location counter write data |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 16 | Memory write address |
| mem_wdata | output | 16 | Memory write data |
| status | output | 5 | Status word (bit map in R5) |
| irq_disarm | output | 1 | Pulse: disable and disarm all interrupts |
| disp_refresh | output | 1 | Pulse: reload the display latches |
| lamp_test_o | output | 1 | Lamp-test drive |

## Verification
Results that come from a button appear three edges after the button input changes: two synchronizer stages, then the registered action. Results that come from the synchronous inputs `line_tick`, `halt_instr` and `wake_irq` appear after a single edge. The lamp-test output follows its input after two edges. The bench drives every input at a falling edge and keeps a cycle counter. A falling-edge monitor logs each strobe together with its cycle number, so the bench can compare the logged cycle with the press cycle plus the expected delay. Level results such as `sw_reg` and `status` are read only after the bench has waited at least that many edges.

// File: rtl/console_pkg.sv
package console_pkg;

  typedef enum logic [1:0] {
    KEY_OFF  = 2'd0,
    KEY_ON   = 2'd1,
    KEY_PROG = 2'd2,
    KEY_LOCK = 2'd3
  } key_e;

  // command bit positions, lowest index has highest priority
  localparam int NCMD        = 9;
  localparam int CMD_MCLR    = 0;
  localparam int CMD_HALT    = 1;
  localparam int CMD_RUN     = 2;
  localparam int CMD_SET_ST  = 3;
  localparam int CMD_SET_L   = 4;
  localparam int CMD_SET_REG = 5;
  localparam int CMD_STORE   = 6;
  localparam int CMD_INC_ST  = 7;
  localparam int CMD_SW_CLR  = 8;

  localparam logic [NCMD-1:0] MASK_ALL     = 9'b1_1111_1111;
  localparam logic [NCMD-1:0] MASK_RUNNING = 9'b1_0000_0111;
  localparam logic [NCMD-1:0] MASK_PROG    = 9'b1_0000_0110;

  // status word layout
  localparam int ST_W     = 5;
  localparam int ST_CARRY = 0;
  localparam int ST_OVF   = 1;
  localparam int ST_PERR  = 2;
  localparam int ST_HALT  = 3;
  localparam int ST_IDIS  = 4;
  localparam logic [ST_W-1:0] ST_CLEARED = 5'b11000;

  // which commands the key position and run state let through
  function automatic logic [NCMD-1:0] cmd_allow(input key_e k, input logic halted);
    case (k)
      KEY_ON:   return halted ? MASK_ALL : MASK_RUNNING;
      KEY_PROG: return MASK_PROG;
      default:  return '0;
    endcase
  endfunction

  // operator status edit: halt flag always kept from the old word
  function automatic logic [ST_W-1:0] merge_status(input logic [ST_W-1:0] old_st,
                                                   input logic [ST_W-1:0] sw_bits);
    logic [ST_W-1:0] r;
    r          = sw_bits;
    r[ST_HALT] = old_st[ST_HALT];
    return r;
  endfunction

endpackage

// File: rtl/btn_sync.sv
module btn_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] btn,
  output logic [W-1:0] rise
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2, prev;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1   <= 1'b0;
        s2   <= 1'b0;
        prev <= 1'b0;
      end else begin
        s1   <= btn[i];
        s2   <= s1;
        prev <= s2;
      end
    end
    assign rise[i] = s2 & ~prev;
  end

endmodule

// File: rtl/cmd_arbiter.sv
module cmd_arbiter #(
  parameter int N = 9
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);

  always_comb begin
    logic found;
    found = 1'b0;
    grant = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !found) begin
        grant[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end

endmodule

// File: rtl/console_seq.sv
module console_seq
  import console_pkg::*;
#(
  parameter  int DW     = 16,
  parameter  int N_REGS = 5,
  localparam int SEL_W  = $clog2(N_REGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       key_mode,
  input  logic [DW-1:0]    data_btn,
  input  logic [NCMD-1:0]  cmd_btn,
  input  logic             lamp_test,
  input  logic [SEL_W-1:0] reg_sel,
  input  logic [DW-1:0]    l_value,
  input  logic             line_tick,
  input  logic             refresh_inhibit,
  input  logic             halt_instr,
  input  logic             wake_irq,
  output logic [DW-1:0]    sw_reg,
  output logic             reg_we,
  output logic [SEL_W-1:0] reg_wsel,
  output logic [DW-1:0]    reg_wdata,
  output logic             l_we,
  output logic [DW-1:0]    l_wdata,
  output logic             mem_we,
  output logic [DW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  output logic [ST_W-1:0]  status,
  output logic             irq_disarm,
  output logic             disp_refresh,
  output logic             lamp_test_o
);

  function automatic logic [DW-1:0] next_addr(input logic [DW-1:0] a);
    return a + DW'(1);
  endfunction

  // named internal events
  logic [DW-1:0]   data_rise;
  logic [NCMD-1:0] cmd_rise;
  logic [NCMD-1:0] cmd_ok;
  logic [NCMD-1:0] grant;
  logic            halted;
  logic            data_ok;
  logic            sel_ok;
  logic            halt_evt;
  logic            wake_evt;
  logic            console_evt;
  logic            tick_evt;
  key_e            key;
  logic            lamp_s1, lamp_s2;

  logic [DW-1:0]   sw_d;
  logic [ST_W-1:0] st_d;
  logic [DW-1:0]   inc_addr;

  btn_sync #(.W(DW)) u_data_sync (
    .clk (clk), .rst_n (rst_n), .btn (data_btn), .rise (data_rise)
  );

  btn_sync #(.W(NCMD)) u_cmd_sync (
    .clk (clk), .rst_n (rst_n), .btn (cmd_btn), .rise (cmd_rise)
  );

  cmd_arbiter #(.N(NCMD)) u_arb (
    .req (cmd_rise & cmd_ok), .grant (grant)
  );

  assign key      = key_e'(key_mode);
  assign halted   = status[ST_HALT];
  assign cmd_ok   = cmd_allow(key, halted);
  assign data_ok  = (key == KEY_ON) || (key == KEY_PROG);
  assign sel_ok   = int'(reg_sel) < N_REGS;
  assign inc_addr = next_addr(l_value);

  assign halt_evt    = grant[CMD_HALT] | halt_instr;
  assign wake_evt    = grant[CMD_RUN] | wake_irq;
  assign console_evt = grant[CMD_SET_ST] | grant[CMD_SET_L] | grant[CMD_SET_REG]
                     | grant[CMD_STORE] | grant[CMD_INC_ST];
  assign tick_evt    = line_tick & ~halted & ~refresh_inhibit;

  always_comb begin
    sw_d = sw_reg;
    if (data_ok) begin
      if (grant[CMD_SW_CLR]) sw_d = '0;
      sw_d = sw_d | data_rise;
    end
  end

  always_comb begin
    st_d = status;
    if (grant[CMD_MCLR]) begin
      st_d = ST_CLEARED;
    end else begin
      if (grant[CMD_SET_ST]) st_d = merge_status(status, sw_reg[ST_W-1:0]);
      if (halt_evt)          st_d[ST_HALT] = 1'b1;
      else if (wake_evt)     st_d[ST_HALT] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_reg       <= '0;
      status       <= ST_CLEARED;
      reg_we       <= 1'b0;
      reg_wsel     <= '0;
      reg_wdata    <= '0;
      l_we         <= 1'b0;
      l_wdata      <= '0;
      mem_we       <= 1'b0;
      mem_addr     <= '0;
      mem_wdata    <= '0;
      irq_disarm   <= 1'b0;
      disp_refresh <= 1'b0;
      lamp_s1      <= 1'b0;
      lamp_s2      <= 1'b0;
    end else begin
      sw_reg       <= sw_d;
      status       <= st_d;
      reg_we       <= (grant[CMD_SET_REG] & sel_ok) | grant[CMD_STORE] | grant[CMD_INC_ST];
      reg_wsel     <= grant[CMD_SET_REG] ? reg_sel : '0;
      reg_wdata    <= sw_reg;
      l_we         <= grant[CMD_SET_L] | grant[CMD_INC_ST];
      l_wdata      <= grant[CMD_INC_ST] ? inc_addr : sw_reg;
      mem_we       <= grant[CMD_STORE] | grant[CMD_INC_ST];
      mem_addr     <= grant[CMD_INC_ST] ? inc_addr : l_value;
      mem_wdata    <= sw_reg;
      irq_disarm   <= grant[CMD_MCLR];
      disp_refresh <= tick_evt | halt_evt | console_evt;
      lamp_s1      <= lamp_test;
      lamp_s2      <= lamp_s1;
    end
  end

  assign lamp_test_o = lamp_s2 & (key != KEY_OFF);

endmodule

// File: rtl/console_seq_chk.sv
module console_seq_chk
  import console_pkg::*;
#(
  parameter int DW    = 16,
  parameter int SEL_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       key_mode,
  input logic [ST_W-1:0]  status,
  input logic [NCMD-1:0]  grant,
  input logic             halt_instr,
  input logic             wake_irq,
  input logic             reg_we,
  input logic [SEL_W-1:0] reg_wsel,
  input logic [DW-1:0]    reg_wdata,
  input logic             l_we,
  input logic             mem_we,
  input logic [DW-1:0]    mem_wdata,
  input logic [DW-1:0]    sw_reg,
  input logic             irq_disarm
);

  assert_writes_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (key_mode != 2'd1 || !status[ST_HALT]) |=> !(l_we || mem_we));

  assert_store_through_m_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (reg_we && reg_wsel == '0 && reg_wdata == mem_wdata));

  assert_locked_panel_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (key_mode == 2'd3 || key_mode == 2'd0) |=> ($stable(sw_reg) && !reg_we && !l_we));

  assert_single_command_R14: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  assert_halt_has_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[ST_HALT]) |-> $past(grant[CMD_MCLR] || grant[CMD_HALT] || halt_instr));

  assert_status_edit_keeps_halt_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (grant[CMD_SET_ST] && !wake_irq) |=> status[ST_HALT] == $past(status[ST_HALT]));

  assert_master_clear_R13: assert property (@(posedge clk) disable iff (!rst_n)
    grant[CMD_MCLR] |=> (status == ST_CLEARED && irq_disarm));

endmodule

bind console_seq console_seq_chk #(.DW(DW), .SEL_W(SEL_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .key_mode   (key_mode),
  .status     (status),
  .grant      (grant),
  .halt_instr (halt_instr),
  .wake_irq   (wake_irq),
  .reg_we     (reg_we),
  .reg_wsel   (reg_wsel),
  .reg_wdata  (reg_wdata),
  .l_we       (l_we),
  .mem_we     (mem_we),
  .mem_wdata  (mem_wdata),
  .sw_reg     (sw_reg),
  .irq_disarm (irq_disarm)
);

// File: tb/tb_console_seq.sv
module tb_console_seq;

  localparam int DW = 16;
  localparam logic [8:0] B_MCLR = 9'h001, B_HALT = 9'h002, B_RUN = 9'h004,
                         B_SETST = 9'h008, B_SETL = 9'h010, B_SETREG = 9'h020,
                         B_STORE = 9'h040, B_INC = 9'h080, B_CLR = 9'h100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] key_mode = 2'd1;
  logic [DW-1:0] data_btn = '0;
  logic [8:0] cmd_btn = '0;
  logic lamp_test = 1'b0;
  logic [2:0] reg_sel = '0;
  logic [DW-1:0] l_value = '0;
  logic line_tick = 1'b0, refresh_inhibit = 1'b0, halt_instr = 1'b0, wake_irq = 1'b0;

  logic [DW-1:0] sw_reg, reg_wdata, l_wdata, mem_addr, mem_wdata;
  logic [2:0] reg_wsel;
  logic [4:0] status;
  logic reg_we, l_we, mem_we, irq_disarm, disp_refresh, lamp_test_o;

  console_seq dut (
    .clk(clk), .rst_n(rst_n), .key_mode(key_mode), .data_btn(data_btn),
    .cmd_btn(cmd_btn), .lamp_test(lamp_test), .reg_sel(reg_sel), .l_value(l_value),
    .line_tick(line_tick), .refresh_inhibit(refresh_inhibit), .halt_instr(halt_instr),
    .wake_irq(wake_irq), .sw_reg(sw_reg), .reg_we(reg_we), .reg_wsel(reg_wsel),
    .reg_wdata(reg_wdata), .l_we(l_we), .l_wdata(l_wdata), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .status(status),
    .irq_disarm(irq_disarm), .disp_refresh(disp_refresh), .lamp_test_o(lamp_test_o)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_err = 0;
  int n_reg, n_l, n_mem, n_ref, n_dis, t0, l_cyc, ref_cyc;
  logic [2:0] lr_sel;
  logic [DW-1:0] lr_dat, ll_dat, lm_addr, lm_dat;

  always @(negedge clk) if (rst_n) begin
    if (reg_we) begin n_reg++; lr_sel = reg_wsel; lr_dat = reg_wdata; end
    if (l_we) begin n_l++; ll_dat = l_wdata; l_cyc = cyc; end
    if (mem_we) begin n_mem++; lm_addr = mem_addr; lm_dat = mem_wdata; end
    if (disp_refresh) begin n_ref++; ref_cyc = cyc; end
    if (irq_disarm) n_dis++;
  end

  function automatic logic [4:0] exp_status_edit(input logic [4:0] old_st, input logic [DW-1:0] sw);
    return {sw[4], old_st[3], sw[2:0]};
  endfunction

  function automatic logic [DW-1:0] exp_inc(input logic [DW-1:0] a);
    return (a == 16'hFFFF) ? 16'h0000 : a + 16'd1;
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clr_log();
    n_reg = 0; n_l = 0; n_mem = 0; n_ref = 0; n_dis = 0; l_cyc = -1; ref_cyc = -1;
  endtask

  task automatic press(input logic [8:0] m);
    clr_log();
    cmd_btn = m; t0 = cyc;
    tick(4);
    cmd_btn = '0;
    tick(4);
  endtask

  task automatic load_sw(input logic [DW-1:0] v);
    press(B_CLR);
    data_btn = v; tick(4); data_btn = '0; tick(4);
  endtask

  task automatic pulse(ref logic s);
    clr_log();
    s = 1'b1; t0 = cyc; tick(1); s = 1'b0; tick(2);
  endtask

  logic [DW-1:0] model, v;
  logic [4:0] st_m;

  initial begin : main
    int unused_seed;
    unused_seed = $urandom(32'h1A2B);
    clr_log();
    tick(4); rst_n = 1'b1; tick(2);

    chk("R1 reset sw_reg", sw_reg, 0);
    chk("R13 reset status", status, 5'b11000);

    // R1 latency of a single press
    data_btn = 16'h0010; tick(2);
    chk("R1 sw before due edge", sw_reg, 0);
    tick(1);
    chk("R1 sw at due edge", sw_reg, 16'h0010);
    data_btn = '0; tick(4);

    // R1 random presses accumulate
    model = 16'h0010;
    for (int i = 0; i < 24; i++) begin
      int b;
      b = $urandom % DW;
      data_btn = 16'(1) << b; tick(4); data_btn = '0; tick(3);
      model[b] = 1'b1;
    end
    chk("R1 random accumulation", sw_reg, model);

    // R2 clear
    press(B_CLR);
    chk("R2 cleared", sw_reg, 0);
    chk("R2 no writes", n_reg + n_l + n_mem, 0);
    clr_log();
    cmd_btn = B_CLR; data_btn = 16'h8001; tick(4); cmd_btn = '0; data_btn = '0; tick(4);
    chk("R2 press survives clear", sw_reg, 16'h8001);

    // R3 set location
    load_sw(16'hA5C3);
    press(B_SETL);
    chk("R3 l_we count", n_l, 1);
    chk("R3 l_wdata", ll_dat, 16'hA5C3);
    chk("R3 latency", l_cyc - t0, 3);
    chk("R9 console command refresh", n_ref, 1);

    // R4 set register, all select codes
    for (int s = 0; s < 8; s++) begin
      v = 16'($urandom);
      load_sw(v);
      reg_sel = 3'(s);
      press(B_SETREG);
      chk("R4 reg_we count", n_reg, (s < 5) ? 1 : 0);
      if (s < 5) begin
        chk("R4 reg_wsel", lr_sel, s);
        chk("R4 reg_wdata", lr_dat, v);
      end
    end
    reg_sel = '0;

    // R5 status edits keep halt
    load_sw(16'h0017);
    press(B_SETST);
    st_m = exp_status_edit(5'b11000, 16'h0017);
    chk("R5 status set", status, st_m);
    load_sw(16'h0000);
    press(B_SETST);
    chk("R5 halt kept on clear", status, exp_status_edit(st_m, 16'h0000));

    // R6 store
    l_value = 16'h0123;
    load_sw(16'hBEEF);
    press(B_STORE);
    chk("R6 mem_we", n_mem, 1);
    chk("R6 mem_addr", lm_addr, 16'h0123);
    chk("R6 mem_wdata", lm_dat, 16'hBEEF);
    chk("R6 M write", {n_reg, 13'd0, lr_sel, lr_dat}, {32'd1, 13'd0, 3'd0, 16'hBEEF});
    chk("R6 no L write", n_l, 0);

    // R7 increment-store incl. wrap
    for (int k = 0; k < 2; k++) begin
      l_value = (k == 0) ? 16'h0123 : 16'hFFFF;
      press(B_INC);
      chk("R7 l_wdata", ll_dat, exp_inc(l_value));
      chk("R7 mem_addr", lm_addr, exp_inc(l_value));
      chk("R7 mem_wdata", lm_dat, 16'hBEEF);
    end

    // R9 no periodic refresh while halted
    pulse(line_tick);
    chk("R9 halted tick ignored", n_ref, 0);

    // R8 run, then set ignored while running
    press(B_RUN);
    chk("R8 run clears halt", status[3], 0);
    press(B_SETL);
    chk("R3 set L ignored in run", n_l, 0);
    press(B_SETST);
    chk("R3 status unchanged in run", status, 5'b00000);
    pulse(line_tick);
    chk("R9 tick refresh", n_ref, 1);
    chk("R9 tick latency", ref_cyc - t0, 1);
    refresh_inhibit = 1'b1;
    pulse(line_tick);
    chk("R9 inhibited tick", n_ref, 0);

    // R10 halt instruction and wake interrupt
    pulse(halt_instr);
    chk("R10 halt instr", status[3], 1);
    chk("R9 halt refresh", n_ref, 1);
    pulse(wake_irq);
    chk("R10 wake clears halt", status[3], 0);
    clr_log();
    halt_instr = 1'b1; wake_irq = 1'b1; tick(1); halt_instr = 1'b0; wake_irq = 1'b0; tick(2);
    chk("R10 halt beats wake", status[3], 1);
    refresh_inhibit = 1'b0;
    press(B_RUN);
    press(B_HALT);
    chk("R8 halt button", status[3], 1);
    chk("R9 halt button refresh", n_ref, 1);

    // R12 PROG mode
    key_mode = 2'd2;
    load_sw(16'h0F0F);
    chk("R12 data works", sw_reg, 16'h0F0F);
    press(B_SETL);
    chk("R12 set L ignored", n_l, 0);
    press(B_MCLR);
    chk("R12 master clear ignored", n_dis, 0);
    press(B_RUN);
    chk("R12 run works", status[3], 0);
    press(B_HALT);
    chk("R12 halt works", status[3], 1);

    // R11 LOCK and OFF
    key_mode = 2'd3;
    data_btn = 16'hF000; tick(4); data_btn = '0; tick(4);
    chk("R11 lock data ignored", sw_reg, 16'h0F0F);
    press(B_SETL | B_RUN);
    chk("R11 lock cmds ignored", {n_l, 31'd0, status[3]}, {32'd0, 31'd0, 1'b1});
    lamp_test = 1'b1; tick(1);
    chk("R11 lamp not yet", lamp_test_o, 0);
    tick(1);
    chk("R11 lamp in lock", lamp_test_o, 1);
    key_mode = 2'd0; tick(1);
    chk("R11 lamp off key", lamp_test_o, 0);
    press(B_CLR);
    chk("R11 off clear ignored", sw_reg, 16'h0F0F);
    lamp_test = 1'b0;

    // R13 master clear
    key_mode = 2'd1;
    load_sw(16'h0007);
    press(B_SETST);
    press(B_MCLR);
    chk("R13 status", status, 5'b11000);
    chk("R13 disarm", n_dis, 1);
    chk("R13 sw kept", sw_reg, 16'h0007);

    // R14 priority
    press(B_MCLR | B_SETL);
    chk("R14 mclr beats set L", {n_dis, n_l}, {32'd1, 32'd0});
    load_sw(16'h0013);
    press(B_SETST | B_SETL | B_CLR);
    chk("R14 set status wins", status, exp_status_edit(5'b11000, 16'h0013));
    chk("R14 others dropped", n_l + n_reg, 0);
    chk("R14 sw not cleared", sw_reg, 16'h0013);

    // mixed random commands while halted
    for (int i = 0; i < 20; i++) begin
      int op;
      v = 16'($urandom);
      l_value = 16'($urandom);
      reg_sel = 3'($urandom % 5);
      load_sw(v);
      op = $urandom % 3;
      press(op == 0 ? B_SETL : (op == 1 ? B_SETREG : B_STORE));
      if (op == 0) chk("R3 random set L", ll_dat, v);
      else if (op == 1) chk("R4 random set reg", {13'd0, lr_sel, lr_dat}, {13'd0, reg_sel, v});
      else chk("R6 random store", {lm_addr, lm_dat}, {l_value, v});
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule